// File: doc/BRIEF.md
# Configurable Split-Port RAM

A fixed-capacity storage block with one write port and one read port. Each port has its own clock and its own clock enable. The total number of bits stored is fixed by a parameter (16,384 by default). The data width is chosen from 1, 2, 4, 8, 16 or 32 bits, and the address width follows from it, so that depth times width always equals the capacity.

The write port always captures its address, data, write enable and two chip selects in registers on the write clock. The read port can place a register on its address, on its data, on both or on neither, and each choice is made by its own parameter.

Per-instance parameters set the active edge of each clock, the active level of each clock enable and the active level of a local reset input. The block's reset is the OR of an active-low global reset and that local reset. It clears the pipeline registers asynchronously, and each clock domain releases it synchronously. The memory contents are left intact by reset.

Top module: `cfg_pdp_ram`

## Requirements
- R1: Depth is TOTAL_BITS/DATA_W and the address width is log2 of that depth (TOTAL_BITS=16384, DATA_W=8 gives 2048 words and 11 address bits); every address holds its own word.
- R2: A write is captured only at a write clock edge where wen=1, wcs=2'b11 and the write clock enable is active; any other combination leaves the stored word unchanged.
- R3: The effective write clock enable is wce XOR WCE_LOW, and the effective read clock enable is rce XOR RCE_LOW.
- R4: With RADDR_REG=1 and RDATA_REG=1, an address presented before read edge k appears on rdata just after read edge k+1, and not after edge k alone.
- R5: With RADDR_REG=0 and RDATA_REG=0, rdata follows raddr combinationally, and a word captured at write edge e is readable from write edge e+1 onward.
- R6: With both read registers present, a read and a write to the same address presented before the same clock edge return the word held before that write.
- R7: While the effective read clock enable is inactive, the read address and read data registers hold their values.
- R8: Effective reset is asserted when gbl_rst_n=0 or (loc_rst XOR LRST_LOW)=1. It clears rdata (when registered), the read address register and any captured but uncommitted write without waiting for a clock, and each domain releases it after SYNC_STAGES edges of its own clock. Stored words survive reset.
- R9: WCLK_FALL=1 (RCLK_FALL=1) moves the write (read) side to the falling edge of its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gbl_rst_n | input | 1 | Global reset, active low |
| loc_rst | input | 1 | Local reset, level set by LRST_LOW |
| wclk | input | 1 | Write clock, edge set by WCLK_FALL |
| wce | input | 1 | Write clock enable, level set by WCE_LOW |
| wen | input | 1 | Write enable |
| wcs | input | 2 | Write chip selects, both must be 1 |
| waddr | input | AW | Write address |
| wdata | input | DATA_W | Write data |
| rclk | input | 1 | Read clock, edge set by RCLK_FALL |
| rce | input | 1 | Read clock enable, level set by RCE_LOW |
| raddr | input | AW | Read address |
| rdata | output | DATA_W | Read data |

## Verification
The hardest case to reach from the ports is a reset that arrives after a write has been captured but before that write reaches the array. The bench captures a write on one edge and raises the local reset in the middle of the same cycle. After the reset is released, it reads that address back and expects the old word. The same-edge read/write collision and the falling-edge write timing are reached in a similar way: the inputs change at offsets within a cycle, and the bench samples the output between the edges that each case depends on.

// File: rtl/pdpr_pkg.sv
`timescale 1ns/1ps
package pdpr_pkg;

  // Address bits needed to cover a fixed capacity at a given word width.
  function automatic int addr_bits(input int total_bits, input int data_w);
    return $clog2(total_bits / data_w);
  endfunction

  // Legal word widths of the array.
  function automatic bit width_ok(input int data_w);
    return (data_w == 1) || (data_w == 2) || (data_w == 4) ||
           (data_w == 8) || (data_w == 16) || (data_w == 32);
  endfunction

endpackage

// File: rtl/pdpr_rst_sync.sv
`timescale 1ns/1ps
module pdpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  // Next state: shift a one in from the bottom.
  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  // Register: assert at once, release after STAGES edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/pdpr_wr_stage.sv
`timescale 1ns/1ps
module pdpr_wr_stage #(
  parameter int AW     = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              wen,
  input  logic [1:0]        wcs,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic              vld_q,
  output logic [AW-1:0]     addr_q,
  output logic [DATA_W-1:0] data_q
);

  logic              vld_d;
  logic [AW-1:0]     addr_d;
  logic [DATA_W-1:0] data_d;

  // Next state: sample the request only on enabled edges.
  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    data_d = data_q;
    if (ce) begin
      vld_d  = wen & (&wcs);
      addr_d = waddr;
      data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/pdpr_array.sv
`timescale 1ns/1ps
module pdpr_array #(
  parameter int AW     = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Storage is never reset; the committed write lands one edge after capture.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/pdpr_rd_path.sv
`timescale 1ns/1ps
module pdpr_rd_path #(
  parameter int AW        = 11,
  parameter int DATA_W    = 8,
  parameter int RADDR_REG = 1,
  parameter int RDATA_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [AW-1:0]     raddr,
  input  logic [DATA_W-1:0] rd_word,
  output logic [AW-1:0]     rd_addr_eff,
  output logic [DATA_W-1:0] rdata
);

  if (RADDR_REG != 0) begin : g_areg
    logic [AW-1:0] a_q;
    logic [AW-1:0] a_d;
    always_comb begin
      a_d = ce ? raddr : a_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
      end else begin
        a_q <= a_d;
      end
    end
    assign rd_addr_eff = a_q;
  end else begin : g_aflow
    assign rd_addr_eff = raddr;
  end

  if (RDATA_REG != 0) begin : g_dreg
    logic [DATA_W-1:0] d_q;
    logic [DATA_W-1:0] d_d;
    always_comb begin
      d_d = ce ? rd_word : d_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
      end else begin
        d_q <= d_d;
      end
    end
    assign rdata = d_q;
  end else begin : g_dflow
    assign rdata = rd_word;
  end

endmodule

// File: rtl/cfg_pdp_ram.sv
`timescale 1ns/1ps
module cfg_pdp_ram #(
  parameter int TOTAL_BITS  = 16384,
  parameter int DATA_W      = 8,
  parameter int RADDR_REG   = 1,
  parameter int RDATA_REG   = 1,
  parameter int WCLK_FALL   = 0,
  parameter int RCLK_FALL   = 0,
  parameter int WCE_LOW     = 0,
  parameter int RCE_LOW     = 0,
  parameter int LRST_LOW    = 0,
  parameter int SYNC_STAGES = 2,
  localparam int AW = pdpr_pkg::addr_bits(TOTAL_BITS, DATA_W)
) (
  input  logic              gbl_rst_n,
  input  logic              loc_rst,
  input  logic              wclk,
  input  logic              wce,
  input  logic              wen,
  input  logic [1:0]        wcs,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rce,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int   DEPTH     = 1 << AW;
  localparam logic WCE_FLIP  = (WCE_LOW != 0);
  localparam logic RCE_FLIP  = (RCE_LOW != 0);
  localparam logic LRST_FLIP = (LRST_LOW != 0);

  if (!pdpr_pkg::width_ok(DATA_W) || (DEPTH * DATA_W != TOTAL_BITS)) begin : g_bad_cfg
    $error("cfg_pdp_ram: unsupported width/capacity combination");
  end

  logic              wclk_i;
  logic              rclk_i;
  logic              wce_on;
  logic              rce_on;
  logic              rst_comb_n;
  logic              rst_w_n;
  logic              rst_r_n;
  logic              wr_vld_q;
  logic [AW-1:0]     wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [AW-1:0]     rd_addr_eff;
  logic [DATA_W-1:0] rd_word;

  // Edge, enable level and reset level selection.
  if (WCLK_FALL != 0) begin : g_wneg
    assign wclk_i = ~wclk;
  end else begin : g_wpos
    assign wclk_i = wclk;
  end

  if (RCLK_FALL != 0) begin : g_rneg
    assign rclk_i = ~rclk;
  end else begin : g_rpos
    assign rclk_i = rclk;
  end

  assign wce_on     = wce ^ WCE_FLIP;
  assign rce_on     = rce ^ RCE_FLIP;
  assign rst_comb_n = gbl_rst_n & ~(loc_rst ^ LRST_FLIP);

  pdpr_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk    (wclk_i),
    .arst_n (rst_comb_n),
    .srst_n (rst_w_n)
  );

  pdpr_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (
    .clk    (rclk_i),
    .arst_n (rst_comb_n),
    .srst_n (rst_r_n)
  );

  pdpr_wr_stage #(.AW(AW), .DATA_W(DATA_W)) u_wr (
    .clk    (wclk_i),
    .rst_n  (rst_w_n),
    .ce     (wce_on),
    .wen    (wen),
    .wcs    (wcs),
    .waddr  (waddr),
    .wdata  (wdata),
    .vld_q  (wr_vld_q),
    .addr_q (wr_addr_q),
    .data_q (wr_data_q)
  );

  pdpr_array #(.AW(AW), .DATA_W(DATA_W)) u_mem (
    .clk     (wclk_i),
    .wr_en   (wr_vld_q),
    .wr_addr (wr_addr_q),
    .wr_data (wr_data_q),
    .rd_addr (rd_addr_eff),
    .rd_word (rd_word)
  );

  pdpr_rd_path #(
    .AW(AW), .DATA_W(DATA_W), .RADDR_REG(RADDR_REG), .RDATA_REG(RDATA_REG)
  ) u_rd (
    .clk         (rclk_i),
    .rst_n       (rst_r_n),
    .ce          (rce_on),
    .raddr       (raddr),
    .rd_word     (rd_word),
    .rd_addr_eff (rd_addr_eff),
    .rdata       (rdata)
  );

endmodule

// File: rtl/cfg_pdp_ram_chk.sv
`timescale 1ns/1ps
module cfg_pdp_ram_chk #(
  parameter int AW        = 11,
  parameter int DATA_W    = 8,
  parameter int RADDR_REG = 1,
  parameter int RDATA_REG = 1
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_w_n,
  input logic              rst_r_n,
  input logic              wce_on,
  input logic              rce_on,
  input logic              wen,
  input logic [1:0]        wcs,
  input logic [AW-1:0]     waddr,
  input logic [AW-1:0]     raddr,
  input logic              wr_vld_q,
  input logic [AW-1:0]     wr_addr_q,
  input logic [AW-1:0]     rd_addr_eff,
  input logic [DATA_W-1:0] rdata
);

  // R2
  wr_block_chk: assert property (@(posedge wclk_i) disable iff (!rst_w_n)
    (wce_on && !(wen && (&wcs))) |=> !wr_vld_q);

  // R2
  wr_take_chk: assert property (@(posedge wclk_i) disable iff (!rst_w_n)
    (wce_on && wen && (&wcs)) |=> (wr_vld_q && wr_addr_q == $past(waddr)));

  // R8
  wr_rst_chk: assert property (@(posedge wclk_i) !rst_w_n |-> !wr_vld_q);

  if (RADDR_REG != 0) begin : g_achk
    // R4
    rd_addr_pipe_chk: assert property (@(posedge rclk_i) disable iff (!rst_r_n)
      rce_on |=> rd_addr_eff == $past(raddr));
    // R7
    rd_addr_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_r_n)
      !rce_on |=> $stable(rd_addr_eff));
  end

  if (RDATA_REG != 0) begin : g_dchk
    // R7
    rd_data_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_r_n)
      !rce_on |=> $stable(rdata));
    // R8
    rd_rst_clear_chk: assert property (@(posedge rclk_i) !rst_r_n |-> rdata == '0);
  end

endmodule

bind cfg_pdp_ram cfg_pdp_ram_chk #(
  .AW(AW), .DATA_W(DATA_W), .RADDR_REG(RADDR_REG), .RDATA_REG(RDATA_REG)
) u_chk (
  .wclk_i      (wclk_i),
  .rclk_i      (rclk_i),
  .rst_w_n     (rst_w_n),
  .rst_r_n     (rst_r_n),
  .wce_on      (wce_on),
  .rce_on      (rce_on),
  .wen         (wen),
  .wcs         (wcs),
  .waddr       (waddr),
  .raddr       (raddr),
  .wr_vld_q    (wr_vld_q),
  .wr_addr_q   (wr_addr_q),
  .rd_addr_eff (rd_addr_eff),
  .rdata       (rdata)
);

// File: tb/sim_cfg_pdp_ram.sv
`timescale 1ns/1ps
module sim_cfg_pdp_ram;

  // Small instances: 256-bit capacity.
  localparam int CAP = 256;
  localparam int DW0 = 8;
  localparam int AW0 = $clog2(CAP / DW0);
  localparam int DW1 = 16;
  localparam int AW1 = $clog2(CAP / DW1);

  logic clk = 1'b0;
  logic grst_n;
  always #2 clk = ~clk;

  logic           lr0, w0_ce, w0_en, r0_ce;
  logic [1:0]     w0_cs;
  logic [AW0-1:0] w0_a, r0_a;
  logic [DW0-1:0] w0_d, r0_q;
  logic           lr1, w1_ce, w1_en, r1_ce;
  logic [1:0]     w1_cs;
  logic [AW1-1:0] w1_a, r1_a;
  logic [DW1-1:0] w1_d, r1_q;

  logic [DW0-1:0] m0 [1 << AW0];
  logic [DW1-1:0] m1 [1 << AW1];

  int n_chk  = 0;
  int n_fail = 0;

  cfg_pdp_ram #(.TOTAL_BITS(CAP), .DATA_W(DW0)) u0 (
    .gbl_rst_n(grst_n), .loc_rst(lr0), .wclk(clk), .wce(w0_ce), .wen(w0_en),
    .wcs(w0_cs), .waddr(w0_a), .wdata(w0_d), .rclk(clk), .rce(r0_ce),
    .raddr(r0_a), .rdata(r0_q)
  );

  cfg_pdp_ram #(
    .TOTAL_BITS(CAP), .DATA_W(DW1), .RADDR_REG(0), .RDATA_REG(0),
    .WCLK_FALL(1), .WCE_LOW(1), .RCE_LOW(1), .LRST_LOW(1)
  ) u1 (
    .gbl_rst_n(grst_n), .loc_rst(lr1), .wclk(clk), .wce(w1_ce), .wen(w1_en),
    .wcs(w1_cs), .waddr(w1_a), .wdata(w1_d), .rclk(clk), .rce(r1_ce),
    .raddr(r1_a), .rdata(r1_q)
  );

  function automatic logic [DW0-1:0] pat0(input int a);
    return DW0'((a * 37 + 11) % 256);
  endfunction

  function automatic logic [DW1-1:0] pat1(input int a);
    return DW1'((a * 16'h1111) ^ 16'h5a5a);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Registered read of u0: address goes in, two edges later the word is out.
  task automatic read0(input int a);
    r0_a = AW0'(a);
    tick();
    tick();
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    grst_n = 1'b0;
    lr0 = 1'b0; w0_ce = 1'b0; w0_en = 1'b0; w0_cs = 2'b00; w0_a = '0; w0_d = '0;
    r0_ce = 1'b0; r0_a = '0;
    lr1 = 1'b1; w1_ce = 1'b1; w1_en = 1'b0; w1_cs = 2'b00; w1_a = '0; w1_d = '0;
    r1_ce = 1'b1; r1_a = '0;
    repeat (3) tick();
    grst_n = 1'b1;
    repeat (4) tick();

    // R8 reset state of the registered read output
    chk("R8 reset rdata", 32'(r0_q), 32'h0);

    // R1 fill every word of u0, then read every word back
    w0_ce = 1'b1; w0_cs = 2'b11; w0_en = 1'b1;
    for (int a = 0; a < (1 << AW0); a++) begin
      w0_a = AW0'(a); w0_d = pat0(a); m0[a] = pat0(a);
      tick();
    end
    w0_en = 1'b0;
    tick();
    r0_ce = 1'b1;
    for (int a = 0; a < (1 << AW0); a++) begin
      read0(a);
      chk("R1 readback", 32'(r0_q), 32'(m0[a]));
    end

    // R4 two-edge latency of the registered read
    read0(2);
    r0_a = AW0'(20);
    tick();
    chk("R4 after one edge", 32'(r0_q), 32'(m0[2]));
    tick();
    chk("R4 after two edges", 32'(r0_q), 32'(m0[20]));

    // R2 each incomplete write qualification is blocked (R3 covers ce level)
    for (int k = 0; k < 5; k++) begin
      w0_a = AW0'(5); w0_d = ~m0[5];
      w0_en = (k == 3) ? 1'b0 : 1'b1;
      w0_cs = (k == 0) ? 2'b01 : (k == 1) ? 2'b10 : (k == 2) ? 2'b00 : 2'b11;
      w0_ce = (k == 4) ? 1'b0 : 1'b1;
      tick();
      w0_en = 1'b0; w0_ce = 1'b1; w0_cs = 2'b11;
      tick();
      read0(5);
      chk("R2 blocked write", 32'(r0_q), 32'(m0[5]));
    end
    w0_a = AW0'(5); w0_d = 8'hc3; w0_en = 1'b1;
    tick();
    w0_en = 1'b0; m0[5] = 8'hc3;
    tick();
    read0(5);
    chk("R2 qualified write", 32'(r0_q), 32'h0c3);

    // R6 same-edge read and write of one address returns the old word
    w0_a = AW0'(9); w0_d = 8'h5c; w0_en = 1'b1; r0_a = AW0'(9);
    tick();
    w0_en = 1'b0;
    tick();
    chk("R6 old word on collision", 32'(r0_q), 32'(m0[9]));
    m0[9] = 8'h5c;
    tick();
    chk("R6 new word afterwards", 32'(r0_q), 32'h05c);

    // R7 disabled read side holds its output
    r0_ce = 1'b0; r0_a = AW0'(0);
    repeat (3) tick();
    chk("R7 hold with rce off", 32'(r0_q), 32'(m0[9]));
    r0_ce = 1'b1;
    tick();
    tick();
    chk("R7 resumes with rce on", 32'(r0_q), 32'(m0[0]));

    // R8 local reset clears output at once, keeps the array
    read0(9);
    lr0 = 1'b1;
    #1;
    chk("R8 local reset async clear", 32'(r0_q), 32'h0);
    lr0 = 1'b0;
    repeat (3) tick();
    read0(9);
    chk("R8 array kept after reset", 32'(r0_q), 32'(m0[9]));

    // R8 global reset clears output at once
    grst_n = 1'b0;
    #1;
    chk("R8 global reset async clear", 32'(r0_q), 32'h0);
    grst_n = 1'b1;
    repeat (3) tick();

    // R8 reset between capture and commit cancels the write
    w0_a = AW0'(12); w0_d = 8'h77; w0_en = 1'b1;
    tick();
    w0_en = 1'b0;
    lr0 = 1'b1;
    #0.5;
    lr0 = 1'b0;
    repeat (3) tick();
    read0(12);
    chk("R8 pending write cancelled", 32'(r0_q), 32'(m0[12]));

    // R5 fill u1 (falling-edge writes, active-low enable), read flow-through
    w1_ce = 1'b0; w1_cs = 2'b11; w1_en = 1'b1;
    for (int a = 0; a < (1 << AW1); a++) begin
      w1_a = AW1'(a); w1_d = pat1(a); m1[a] = pat1(a);
      tick();
    end
    w1_en = 1'b0;
    tick();
    tick();
    for (int a = 0; a < (1 << AW1); a++) begin
      tick();
      r1_a = AW1'(a);
      #0.5;
      chk("R5 flow-through read", 32'(r1_q), 32'(m1[a]));
    end

    // R9 falling-edge capture: committed at the second falling edge
    tick();
    r1_a = AW1'(3);
    w1_a = AW1'(3); w1_d = 16'hbeef; w1_en = 1'b1;
    #1.5;
    w1_en = 1'b0;
    chk("R9 not yet committed", 32'(r1_q), 32'(m1[3]));
    #4;
    m1[3] = 16'hbeef;
    chk("R9 committed on falling edge", 32'(r1_q), 32'h0beef);

    // R3 inverted write enable: level 1 means disabled
    tick();
    w1_ce = 1'b1; w1_en = 1'b1; w1_d = 16'h1234;
    tick();
    tick();
    w1_en = 1'b0; w1_ce = 1'b0;
    tick();
    #0.5;
    chk("R3 inverted enable blocks write", 32'(r1_q), 32'(m1[3]));

    // R8 inverted local reset keeps the array of u1
    tick();
    lr1 = 1'b0;
    tick();
    tick();
    lr1 = 1'b1;
    repeat (3) tick();
    #0.5;
    chk("R8 inverted local reset keeps array", 32'(r1_q), 32'(m1[3]));

    finish_run();
  end

endmodule